// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block divides a signed 32-bit dividend by a signed 16-bit divisor. It sits on a simple 32-bit register bus that has a write strobe, a byte address, write data and combinational read data. Software first loads the dividend and then writes the divisor. The divisor write is the start command. The block has no separate go bit.

An iterative engine produces one quotient bit per clock and then applies the signs. The quotient truncates toward zero. The remainder carries the sign of the dividend: it is stored as a 16-bit value and read back sign-extended to 32 bits. A status word reports a busy bit while the engine runs and a divide-by-zero flag.

A zero divisor never starts the engine. It loads fixed results at once. A divisor written while a division is running abandons that division and starts a new one from the present dividend.

Top module: `sdiv_top`

## Requirements
- R1: After reset, every readable word (offsets 0x0, 0x4, 0x8, 0xC, 0x10) reads zero.
- R2: A write to offset 0x0 stores the 32-bit dividend. A write to offset 0x4 stores the divisor's low 16 bits, which read back zero-extended.
- R3: A write of a nonzero divisor raises the busy bit (bit 0 of the status word at 0x10). Counting from the write edge, busy stays high for exactly 33 clock cycles: 32 bit steps plus one result cycle.
- R4: When busy falls, offset 0x8 holds the signed quotient, truncated toward zero.
- R5: The remainder takes the sign of the dividend. Offset 0xC holds it in bits 15:0, and bits 31:16 are copies of bit 15.
- R6: A divisor write of zero sets the divide-by-zero flag (status bit 1) and leaves busy low. The quotient becomes 0xFFFFFFFF and the remainder becomes the dividend's low 16 bits, sign-extended.
- R7: Every divisor write refreshes the divide-by-zero flag, so a nonzero divisor clears it.
- R8: A divisor write while busy abandons the running division. A new one starts from the current dividend register, with busy again lasting 33 cycles.
- R9: Writes to offsets 0x8, 0xC and 0x10 have no effect, and status bits 31:2 always read zero.
- R10: A dividend write while busy does not change the running division. Its result uses the dividend present at the divisor write.
- R11: Dividing -2147483648 by -1 gives quotient 0x80000000 and remainder 0 (the low 32 bits of the true result).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 5 | Byte address; the low two bits must be zero for a hit |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |

## Verification
The bound checker checks five properties on every cycle:
- a zero divisor write leaves the block idle with the flag set;
- a nonzero divisor write leaves it busy with the flag clear;
- the quotient register holds still inside a run;
- a dividend write never starts the engine;
- status and remainder reads keep their constant and sign-extended upper bits.

Only the bench's scenarios can show the arithmetic itself: the quotient and remainder across sign combinations, the overflow case, the exact 33-cycle busy length, and which dividend an aborted or disturbed run ends up using.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned ADDR_W = 5;

  localparam logic [2:0] WORD_DIVIDEND = 3'd0;
  localparam logic [2:0] WORD_DIVISOR  = 3'd1;
  localparam logic [2:0] WORD_QUOT     = 3'd2;
  localparam logic [2:0] WORD_REM      = 3'd3;
  localparam logic [2:0] WORD_STATUS   = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } engState_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
    logic zeroRes;
  } engStrobe_t;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int unsigned ITER = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       zeroReq,
  output logic       busy,
  output engStrobe_t strb
);
  localparam int unsigned CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  engState_e state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strb = '0;
    strb.load    = startReq && !zeroReq;
    strb.zeroRes = startReq && zeroReq;
    strb.step    = (state == ST_RUN) && !startReq;
    strb.finish  = (state == ST_FIN) && !startReq;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else if (startReq) begin
      state   <= zeroReq ? ST_IDLE : ST_RUN;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_dpath.sv
module sdiv_dpath
  import sdiv_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned VW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrDividend,
  input  logic          wrDivisor,
  input  logic [DW-1:0] wrData,
  input  engStrobe_t    strb,
  output logic [DW-1:0] dividendVal,
  output logic [VW-1:0] divisorVal,
  output logic [DW-1:0] quotVal,
  output logic [VW-1:0] remVal,
  output logic          zeroFlag
);
  logic [DW-1:0] qShift;
  logic [VW:0]   remAcc;
  logic [VW-1:0] dMag;
  logic          negQ, negR;

  logic [VW-1:0] newDivisor;
  logic [DW-1:0] dvdMag;
  logic [VW:0]   partial;
  logic [VW:0]   diff;
  logic          fits;

  assign newDivisor = wrData[VW-1:0];
  assign dvdMag     = dividendVal[DW-1] ? (~dividendVal + 1'b1) : dividendVal;
  assign partial    = {remAcc[VW-1:0], qShift[DW-1]};
  assign fits       = partial >= {1'b0, dMag};
  assign diff       = partial - {1'b0, dMag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dividendVal <= '0;
      divisorVal  <= '0;
      zeroFlag    <= 1'b0;
    end else begin
      if (wrDividend) dividendVal <= wrData;
      if (wrDivisor) begin
        divisorVal <= newDivisor;
        zeroFlag   <= (newDivisor == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qShift <= '0;
      remAcc <= '0;
      dMag   <= '0;
      negQ   <= 1'b0;
      negR   <= 1'b0;
    end else if (strb.load) begin
      qShift <= dvdMag;
      remAcc <= '0;
      dMag   <= newDivisor[VW-1] ? (~newDivisor + 1'b1) : newDivisor;
      negQ   <= dividendVal[DW-1] ^ newDivisor[VW-1];
      negR   <= dividendVal[DW-1];
    end else if (strb.step) begin
      remAcc <= fits ? diff : partial;
      qShift <= {qShift[DW-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotVal <= '0;
      remVal  <= '0;
    end else if (strb.zeroRes) begin
      quotVal <= '1;
      remVal  <= dividendVal[VW-1:0];
    end else if (strb.finish) begin
      quotVal <= negQ ? (~qShift + 1'b1) : qShift;
      remVal  <= negR ? (~remAcc[VW-1:0] + 1'b1) : remAcc[VW-1:0];
    end
  end
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
  import sdiv_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned VW = DIV_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  logic          aligned;
  logic [2:0]    wordSel;
  logic          wrDividend, wrDivisor, busy, zeroFlag;
  logic [DW-1:0] dividendVal, quotVal;
  logic [VW-1:0] divisorVal, remVal;
  engStrobe_t    strb;

  assign aligned    = (addr[1:0] == 2'b00);
  assign wordSel    = addr[4:2];
  assign wrDividend = wrEn && aligned && (wordSel == WORD_DIVIDEND);
  assign wrDivisor  = wrEn && aligned && (wordSel == WORD_DIVISOR);

  sdiv_ctrl #(.ITER(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (wrDivisor),
    .zeroReq  (wrData[VW-1:0] == '0),
    .busy     (busy),
    .strb     (strb)
  );

  sdiv_dpath #(.DW(DW), .VW(VW)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrDividend  (wrDividend),
    .wrDivisor   (wrDivisor),
    .wrData      (wrData),
    .strb        (strb),
    .dividendVal (dividendVal),
    .divisorVal  (divisorVal),
    .quotVal     (quotVal),
    .remVal      (remVal),
    .zeroFlag    (zeroFlag)
  );

  always_comb begin
    rdData = '0;
    if (aligned) begin
      case (wordSel)
        WORD_DIVIDEND: rdData = dividendVal;
        WORD_DIVISOR:  rdData = {{(DW-VW){1'b0}}, divisorVal};
        WORD_QUOT:     rdData = quotVal;
        WORD_REM:      rdData = {{(DW-VW){remVal[VW-1]}}, remVal};
        WORD_STATUS:   rdData = {{(DW-2){1'b0}}, zeroFlag, busy};
        default:       rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 16,
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wrDivisor,
  input logic          wrDividend,
  input logic [DW-1:0] wrData,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdData,
  input logic          busy,
  input logic          zeroFlag,
  input logic [DW-1:0] quotVal
);
  // R6: zero divisor sets the flag and never starts the engine
  a_r6_zero_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    (wrDivisor && wrData[VW-1:0] == '0) |=> (zeroFlag && !busy));

  // R3, R7: nonzero divisor starts the engine and clears the flag
  a_r7_nonzero_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wrDivisor && wrData[VW-1:0] != '0) |=> (busy && !zeroFlag));

  // R4: the quotient register holds still inside a run
  a_r4_quot_stable_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(quotVal));

  // R10: a dividend write never starts the engine
  a_r10_dividend_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wrDividend && !busy) |=> !busy);

  // R9: status upper bits read zero
  a_r9_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(16)) |-> (rdData[DW-1:2] == '0));

  // R5: remainder read is sign-extended
  a_r5_rem_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(12)) |-> (rdData[DW-1:VW] == {(DW-VW){rdData[VW-1]}}));
endmodule

bind sdiv_top sdiv_chk #(.DW(DW), .VW(VW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrDivisor  (wrDivisor),
  .wrDividend (wrDividend),
  .wrData     (wrData),
  .addr       (addr),
  .rdData     (rdData),
  .busy       (busy),
  .zeroFlag   (zeroFlag),
  .quotVal    (quotVal)
);

// File: tb/sdiv_top_test.sv
module sdiv_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int total = 0;
  int bad = 0;

  sdiv_top uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 5'h10;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
    addr = 5'h10;
  endtask

  // counts cycles of busy after the divisor write edge; caller is at the negedge after it
  task automatic waitIdle(output int cycles);
    logic [31:0] st;
    cycles = 0;
    rd(5'h10, st);
    while (st[0]) begin
      cycles++;
      @(negedge clk);
      rd(5'h10, st);
    end
  endtask

  function automatic logic [31:0] expQ(input logic [31:0] a, input logic [15:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    return 32'(sa / sb);
  endfunction

  function automatic logic [31:0] expR(input logic [31:0] a, input logic [15:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    logic [15:0] r = 16'(sa % sb);
    return {{16{r[15]}}, r};
  endfunction

  task automatic runDiv(input logic [31:0] a, input logic [15:0] b, input string tag);
    int cyc;
    logic [31:0] v;
    wr(5'h00, a);
    wr(5'h04, {16'h0, b});
    waitIdle(cyc);
    total++;
    if (cyc != 33) begin
      bad++;
      $display("FAIL R3 %s busy cycles actual=%0d expected=33", tag, cyc);
    end
    rd(5'h08, v); check({"R4 quotient ", tag}, v, expQ(a, b));
    rd(5'h0C, v); check({"R5 remainder ", tag}, v, expR(a, b));
    rd(5'h10, v); check({"R7 status ", tag}, v, 32'h0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(5'(i * 4), v);
      check("R1 reset value", v, 32'h0);
    end
  endtask

  task automatic testRegs();
    logic [31:0] v;
    wr(5'h00, 32'hDEAD_BEEF);
    rd(5'h00, v); check("R2 dividend readback", v, 32'hDEAD_BEEF);
    wr(5'h04, 32'hABCD_0007);
    rd(5'h04, v); check("R2 divisor readback", v, 32'h0000_0007);
    begin
      int cyc;
      waitIdle(cyc);
    end
  endtask

  task automatic testZero();
    logic [31:0] v;
    wr(5'h00, 32'h1234_9876);
    wr(5'h04, 32'h0);
    rd(5'h10, v); check("R6 status after zero divisor", v, 32'h2);
    rd(5'h08, v); check("R6 quotient all ones", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); check("R6 remainder sext low half", v, 32'hFFFF_9876);
    wr(5'h04, 32'h3);
    rd(5'h10, v); check("R7 flag cleared, busy", v, 32'h1);
    begin
      int cyc;
      waitIdle(cyc);
    end
  endtask

  task automatic testRestart();
    int cyc;
    logic [31:0] v;
    wr(5'h00, 32'd1000);
    wr(5'h04, 32'd7);
    repeat (5) @(negedge clk);
    wr(5'h00, -32'sd500);
    wr(5'h04, 32'h0000_FFFD);
    waitIdle(cyc);
    total++;
    if (cyc != 33) begin
      bad++;
      $display("FAIL R8 busy after restart actual=%0d expected=33", cyc);
    end
    rd(5'h08, v); check("R8 restart quotient", v, expQ(-32'sd500, 16'hFFFD));
    rd(5'h0C, v); check("R8 restart remainder", v, expR(-32'sd500, 16'hFFFD));
  endtask

  task automatic testDividendMidRun();
    int cyc;
    logic [31:0] v;
    wr(5'h00, 32'd99999);
    wr(5'h04, 32'd10);
    wr(5'h00, 32'd5);
    waitIdle(cyc);
    rd(5'h08, v); check("R10 quotient uses dividend at start", v, 32'd9999);
    rd(5'h0C, v); check("R10 remainder uses dividend at start", v, 32'd9);
    rd(5'h00, v); check("R10 new dividend stored", v, 32'd5);
  endtask

  task automatic testIgnored();
    logic [31:0] v;
    wr(5'h08, 32'h5555_5555);
    wr(5'h0C, 32'h6666_6666);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h08, v); check("R9 quotient unchanged", v, 32'd9999);
    rd(5'h0C, v); check("R9 remainder unchanged", v, 32'd9);
    rd(5'h10, v); check("R9 status unchanged", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    addr = 5'h10;
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testRegs();
    runDiv(32'd100, 16'd7, "pos/pos");
    runDiv(-32'sd100, 16'd7, "neg/pos");
    runDiv(32'd100, 16'hFFF9, "pos/neg");
    runDiv(-32'sd100, 16'hFFF9, "neg/neg");
    runDiv(32'h7FFF_FFFF, 16'h8000, "max/minDivisor");
    runDiv(32'h8000_0000, 16'd3, "minDividend");
    runDiv(32'h8000_0000, 16'hFFFF, "R11 overflow");
    testZero();
    testRestart();
    testDividendMidRun();
    testIgnored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule